// File: doc/BRIEF.md
# Write-Once Halfword OTP Array

This block models a bank of one-time-programmable storage as flip-flops behind a simple 32-bit read/write bus. There are 190 words, and each one starts out erased to all ones. Every word is treated as two independent 16-bit halves. A half can leave its erased pattern exactly once, and after that it is locked for good. Reset returns the whole bank to the erased state, because the model stands in for fresh, unprogrammed cells.

Requests are single-cycle. A read returns its data one clock after the request. A write updates storage on the clock edge that accepts it. Each half of a write is guarded on its own, so one locked half does not stop the other half of the same write. Illegal accesses are never silently lost: writes to a locked half and accesses outside the array raise a sticky error flag, which only reset clears.

Top module: `otp_halfword_array`

## Requirements
- R1: After reset every word reads 0xFFFFFFFF and `err_flag` is 0.
- R2: Word n (0 to 189) is addressed at byte offset 0x108 + 4*n. A read request in one cycle makes `rsp_valid` high in the next cycle, with that word on `rsp_rdata`. In a cycle with no read request in the previous cycle, `rsp_valid` is low.
- R3: A write to a half that still holds 0xFFFF stores the written 16-bit value in that half (bits 15:0 lower, bits 31:16 upper).
- R4: A write to a half that no longer holds 0xFFFF leaves it unchanged and sets `err_flag`.
- R5: The two halves of one write are judged independently. In the same write, a locked half is rejected with an error while an erased half is programmed.
- R6: Writing 0xFFFF to an erased half leaves it erased and still programmable, and raises no error.
- R7: A half takes part in a write only if both of its byte strobes are set: `req_strb[1:0]` for the lower half and `req_strb[3:2]` for the upper half. A half with one or no strobe set is unchanged and raises no error.
- R8: An access to an address below 0x108, at or above 0x400, or not 4-byte aligned changes no storage, returns 0 when it is a read, and sets `err_flag`.
- R9: Once set, `err_flag` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the bank |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes for write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| err_flag | output | 1 | Sticky access error |

## Verification
The assertions assume that `req_valid` is low while reset is held, and that the request inputs carry known values whenever `req_valid` is high. Under those conditions the past-cycle index and write data they refer to are meaningful. The bench drives every request on the falling clock edge and holds it for one full cycle. It keeps `req_valid` low during and just after each reset, and it returns all request inputs to zero between operations.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int OTP_DATA_W   = 32;
    localparam int OTP_HALF_W   = OTP_DATA_W / 2;
    localparam int OTP_STRB_W   = OTP_DATA_W / 8;
    localparam int OTP_HALF_STRB = OTP_STRB_W / 2;
    localparam int OTP_NUM_HALVES = 2;

    typedef logic [OTP_HALF_W-1:0] half_t;
    typedef logic [OTP_DATA_W-1:0] word_t;

    localparam half_t HALF_ERASED = '1;
    localparam word_t WORD_ERASED = '1;
endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode #(
    parameter int ADDR_W      = 12,
    parameter int NUM_WORDS   = 190,
    parameter int BASE_OFFSET = 'h108,
    localparam int IDX_W      = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [ADDR_W-1:0]   BASE_L  = ADDR_W'(BASE_OFFSET);
    localparam logic [ADDR_W-3:0]   LIMIT_L = (ADDR_W-2)'(NUM_WORDS);

    logic [ADDR_W-1:0] off_w;
    logic [ADDR_W-3:0] word_w;

    always_comb begin
        off_w  = addr_i - BASE_L;
        word_w = off_w[ADDR_W-1:2];
        hit_o  = (addr_i >= BASE_L) && (off_w[1:0] == 2'b00) && (word_w < LIMIT_L);
        idx_o  = word_w[IDX_W-1:0];
    end
endmodule

// File: rtl/otp_half_guard.sv
module otp_half_guard
    import otp_pkg::*;
(
    input  logic                     wr_req_i,
    input  logic [OTP_HALF_STRB-1:0] strb_i,
    input  half_t                    cur_i,
    input  half_t                    wdata_i,
    output half_t                    nxt_o,
    output logic                     err_o
);
    logic touched_w;
    logic locked_w;

    always_comb begin
        touched_w = wr_req_i && (&strb_i);
        locked_w  = (cur_i != HALF_ERASED);
        nxt_o     = (touched_w && !locked_w) ? wdata_i : cur_i;
        err_o     = touched_w && locked_w;
    end
endmodule

// File: rtl/otp_halfword_array.sv
module otp_halfword_array
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_WORDS   = 190,
    parameter int BASE_OFFSET = 'h108
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [OTP_DATA_W-1:0] req_wdata,
    input  logic [OTP_STRB_W-1:0] req_strb,
    output logic                  rsp_valid,
    output logic [OTP_DATA_W-1:0] rsp_rdata,
    output logic                  err_flag
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    typedef struct {
        word_t mem [NUM_WORDS];
        word_t rdata;
        logic  rsp_valid;
        logic  err;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic             hit_w;
    logic [IDX_W-1:0] idx_w;
    logic             wr_go_w;
    logic             rd_go_w;
    word_t            cur_word_w;
    half_t            half_nxt_w [OTP_NUM_HALVES];
    logic             half_err_w [OTP_NUM_HALVES];

    otp_addr_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_WORDS   (NUM_WORDS),
        .BASE_OFFSET (BASE_OFFSET)
    ) u_decode (
        .addr_i (req_addr),
        .hit_o  (hit_w),
        .idx_o  (idx_w)
    );

    always_comb begin
        wr_go_w    = req_valid && req_write && hit_w;
        rd_go_w    = req_valid && !req_write;
        cur_word_w = hit_w ? state_q.mem[idx_w] : WORD_ERASED;
    end

    for (genvar h = 0; h < OTP_NUM_HALVES; h++) begin : gen_half
        otp_half_guard u_guard (
            .wr_req_i (wr_go_w),
            .strb_i   (req_strb[h*OTP_HALF_STRB +: OTP_HALF_STRB]),
            .cur_i    (cur_word_w[h*OTP_HALF_W +: OTP_HALF_W]),
            .wdata_i  (req_wdata[h*OTP_HALF_W +: OTP_HALF_W]),
            .nxt_o    (half_nxt_w[h]),
            .err_o    (half_err_w[h])
        );
    end

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = rd_go_w;
        if (wr_go_w) begin
            for (int h = 0; h < OTP_NUM_HALVES; h++) begin
                state_d.mem[idx_w][h*OTP_HALF_W +: OTP_HALF_W] = half_nxt_w[h];
                if (half_err_w[h]) begin
                    state_d.err = 1'b1;
                end
            end
        end
        if (rd_go_w) begin
            state_d.rdata = hit_w ? cur_word_w : '0;
        end
        if (req_valid && !hit_w) begin
            state_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                state_q.mem[i] <= WORD_ERASED;
            end
            state_q.rdata     <= '0;
            state_q.rsp_valid <= 1'b0;
            state_q.err       <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_rdata = state_q.rdata;
    assign err_flag  = state_q.err;

    // Read response timing
    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // Erased lower half takes the written value
    p_program_erased_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_w && (&req_strb[1:0]) && state_q.mem[idx_w][15:0] == HALF_ERASED)
        |=> state_q.mem[$past(idx_w)][15:0] == $past(req_wdata[15:0]));

    // Locked lower half is held and flagged
    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_w && (&req_strb[1:0]) && state_q.mem[idx_w][15:0] != HALF_ERASED)
        |=> (state_q.mem[$past(idx_w)][15:0] == $past(state_q.mem[idx_w][15:0])) && err_flag);

    // Out-of-range read returns zero with error
    p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !hit_w) |=> (rsp_rdata == '0) && err_flag);

    // Error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: tb/otp_halfword_array_test.sv
module otp_halfword_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    otp_halfword_array uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_strb  (req_strb),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .err_flag  (err_flag)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h108, 32'h0, 4'h0, 32'hFFFF_FFFF, "R1"},
        '{1'b0, 12'h3FC, 32'h0, 4'h0, 32'hFFFF_FFFF, "R2"},
        '{1'b1, 12'h108, 32'h1234_5678, 4'hF, 32'h0, "R3"},
        '{1'b0, 12'h108, 32'h0, 4'h0, 32'h1234_5678, "R3"},
        '{1'b1, 12'h10C, 32'hFFFF_ABCD, 4'hF, 32'h0, "R6"},
        '{1'b0, 12'h10C, 32'h0, 4'h0, 32'hFFFF_ABCD, "R6"},
        '{1'b1, 12'h10C, 32'h5555_0000, 4'hC, 32'h0, "R6"},
        '{1'b0, 12'h10C, 32'h0, 4'h0, 32'h5555_ABCD, "R6"},
        '{1'b1, 12'h110, 32'h0000_1111, 4'h6, 32'h0, "R7"},
        '{1'b0, 12'h110, 32'h0, 4'h0, 32'hFFFF_FFFF, "R7"},
        '{1'b1, 12'h3FC, 32'hA5A5_5A5A, 4'hF, 32'h0, "R2"},
        '{1'b0, 12'h3FC, 32'h0, 4'h0, 32'hA5A5_5A5A, "R2"},
        '{1'b1, 12'h110, 32'h0000_7777, 4'h3, 32'h0, "R7"},
        '{1'b0, 12'h110, 32'h0, 4'h0, 32'hFFFF_7777, "R7"}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
        req_strb  = s;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        req_strb  = '0;
    endtask

    task automatic do_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        @(negedge clk);
        chk({req, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({req, " rdata"}, rsp_rdata, exp);
        req_valid = 1'b0;
        req_addr  = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 err", {31'b0, err_flag}, 32'd0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].addr, VECS[i].data, VECS[i].strb);
                // R2: no read response after a write
                chk($sformatf("%s vec%0d no rsp", VECS[i].tag, i), {31'b0, rsp_valid}, 32'd0);
            end else begin
                do_read($sformatf("%s vec%0d", VECS[i].tag, i), VECS[i].addr, VECS[i].exp);
            end
        end
        // R6 R7: none of the table traffic raised an error
        chk("R6/R7 no error", {31'b0, err_flag}, 32'd0);

        // R4: rewrite of locked word is ignored
        do_write(12'h108, 32'h0000_0000, 4'hF);
        chk("R4 err", {31'b0, err_flag}, 32'd1);
        do_read("R4 hold", 12'h108, 32'h1234_5678);

        // R5: mixed locked and erased halves in one write
        do_reset();
        do_read("R1 erased after reset", 12'h108, 32'hFFFF_FFFF);
        chk("R9 cleared by reset", {31'b0, err_flag}, 32'd0);
        do_write(12'h114, 32'h0000_0001, 4'h3);
        chk("R5 no err yet", {31'b0, err_flag}, 32'd0);
        do_write(12'h114, 32'hBEEF_0002, 4'hF);
        chk("R5 err", {31'b0, err_flag}, 32'd1);
        do_read("R5 upper programmed", 12'h114, 32'hBEEF_0001);

        // R9: flag survives clean traffic
        do_read("R9 clean read", 12'h10C, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        chk("R9 sticky", {31'b0, err_flag}, 32'd1);

        // R8: below base
        do_reset();
        do_read("R8 below base", 12'h104, 32'h0);
        chk("R8 below err", {31'b0, err_flag}, 32'd1);
        // R8: at end of range
        do_reset();
        do_write(12'h400, 32'h0, 4'hF);
        chk("R8 end write err", {31'b0, err_flag}, 32'd1);
        do_read("R8 end read", 12'h400, 32'h0);
        do_read("R8 last word intact", 12'h3FC, 32'hFFFF_FFFF);
        // R8: unaligned
        do_reset();
        do_write(12'h109, 32'h0, 4'hF);
        chk("R8 unaligned err", {31'b0, err_flag}, 32'd1);
        do_read("R8 unaligned no change", 12'h108, 32'hFFFF_FFFF);
        do_read("R8 unaligned read", 12'h10A, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule